// File: doc/BRIEF.md
# Receive Frame Queue with Early-Collision and Runt Rejection

This block sits between a MAC receive path and the host-side reader of a byte-wide frame queue. The MAC hands it bytes tagged with start-of-frame and end-of-frame markers. Alongside the bytes it supplies a collision indication and a count of bit times measured from the end of the preamble. Each incoming frame is written tentatively behind a speculative write pointer. The frame only becomes visible to the reader when its end arrives and it passes the rejection rules. At that point the committed pointer advances and a length/status entry is queued.

There are three ways a frame is retracted. The first is a collision that arrives while the bit-time count is still inside the 512-bit slot window. The second is a frame shorter than the minimum length while runt acceptance is off; any loopback mode forces runt acceptance on without changing the programmed control bit. The third is a frame that does not fit in the queue. Retraction restores the speculative pointer to the committed one. Frames already committed ahead of the rejected one stay intact and readable. A collision after the slot window does not delete anything: it marks the frame's status as a late collision.

The input stream never stalls: `in_ready` is held high, and a frame that runs out of space is dropped whole, with a one-cycle overflow pulse. The output is a valid/ready stream. When `out_valid` is high and `out_ready` is low, the byte, its last marker, the frame length and the status all hold until the transfer happens.

Top module: `rxq_reject_fifo`

## Requirements
- R1: An accepted frame is delivered on the output stream byte for byte in arrival order. `out_last` marks its final byte, and `out_len` equals its byte count. The first byte is offered on the cycle after the edge that takes the end-of-frame beat.
- R2: A collision seen while a frame is open and `bit_time` is below 512 discards that frame. None of its bytes ever reaches the output.
- R3: A collision with `bit_time` of 512 or more keeps the frame and sets bit 0 (late collision) of `out_stat` for it.
- R4: A frame of fewer than 64 bytes is discarded when `runt_accept` and `loop_en` are both low.
- R5: A frame of fewer than 64 bytes is kept when `runt_accept` or `loop_en` is high. Bit 1 of `out_stat` is set for any kept frame shorter than 64 bytes.
- R6: Discarding a frame leaves every committed, unread frame ahead of it unchanged, and `q_level` keeps its value.
- R7: The reader sees only committed data. `q_level` counts committed unread bytes, and `out_valid` stays low and `q_empty` stays high while the only stored bytes belong to an unfinished frame.
- R8: When a byte of a live frame finds the queue full, or its end finds the length queue full, the whole frame is dropped. `ovf_event` pulses once, one cycle later, and committed frames are unaffected.
- R9: A start-of-frame beat arriving while a frame is still open abandons the open frame and starts the new one.
- R10: Beats without a start marker, and collisions, are ignored while no frame is open.
- R11: While `out_valid` is high and `out_ready` low, `out_valid`, `out_data`, `out_last` and `out_len` hold their values.
- R12: After reset the queue is empty: `out_valid` low, `q_level` zero, `q_empty` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input ready, always high |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| col_det | input | 1 | Collision seen this cycle |
| bit_time | input | BT_W (12) | Bit times since end of preamble |
| runt_accept | input | 1 | Programmed runt acceptance |
| loop_en | input | 1 | Any loopback mode active |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Reader accepts byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends its frame |
| out_len | output | clog2(DEPTH+1) (8) | Byte count of the frame at the head |
| out_stat | output | 2 | Head frame status: bit 0 late collision, bit 1 short frame |
| q_level | output | clog2(DEPTH)+1 (8) | Committed unread bytes |
| q_empty | output | 1 | No committed unread bytes |
| ovf_event | output | 1 | One-cycle pulse when a frame is dropped for lack of space |

## Verification
The in-RTL properties check the following on every cycle:
- the speculative pointer never runs more than the queue depth ahead of the reader;
- the committed pointer moves only on an end-of-frame beat, and not at all on an end-of-frame beat of a short frame that runt acceptance does not cover;
- an early collision snaps the speculative pointer back to the committed one;
- the length queue never overruns or underruns;
- the output holds steady under back-pressure, and an empty level never coexists with a valid output.

Only the bench's scenarios can show the rest:
- that the surviving byte stream, lengths and status bits match the rules;
- that a rejection leaves earlier committed frames intact;
- that loopback forces runt acceptance;
- that an overflow drops exactly one frame with one pulse.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
  typedef struct packed {
    logic short_frm;
    logic late_coll;
  } rxq_stat_t;
endpackage

// File: rtl/rxq_byte_ram.sv
`timescale 1ns/1ps
module rxq_byte_ram #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_meta_fifo.sv
`timescale 1ns/1ps
module rxq_meta_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);
  localparam logic [AW:0] DEPTH_P = (AW+1)'(DEPTH);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0] wp, rp, cnt;

  assign cnt   = wp - rp;
  assign full  = (cnt == DEPTH_P);
  assign valid = (cnt != '0);
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) begin
        mem[wp[AW-1:0]] <= din;
        wp <= wp + (AW+1)'(1);
      end
      if (pop) rp <= rp + (AW+1)'(1);
    end
  end

  AST_META_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst) push |-> !full) // R8
    else $error("length queue written while full");
  AST_META_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst) pop |-> valid) // R1
    else $error("length queue read while empty");
endmodule

// File: rtl/rxq_wr_ctl.sv
`timescale 1ns/1ps
module rxq_wr_ctl #(
  parameter int DEPTH     = 128,
  parameter int MIN_LEN   = 64,
  parameter int SLOT_BITS = 512,
  parameter int BT_W      = 12,
  localparam int PW    = $clog2(DEPTH) + 1,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             col_det,
  input  logic [BT_W-1:0]  bit_time,
  input  logic             runt_ok,
  input  logic [PW-1:0]    rd_ptr,
  input  logic             meta_full,
  output logic             wr_en,
  output logic [PW-1:0]    wr_ptr,
  output logic [PW-1:0]    comm_ptr,
  output logic             push,
  output logic [LEN_W-1:0] push_len,
  output rxq_pkg::rxq_stat_t push_stat,
  output logic             ovf_event
);
  localparam logic [PW-1:0]    DEPTH_P = PW'(DEPTH);
  localparam logic [LEN_W-1:0] MIN_P   = LEN_W'(MIN_LEN);
  localparam logic [BT_W-1:0]  SLOT_P  = BT_W'(SLOT_BITS);

  logic active, bad, late;
  logic [LEN_W-1:0] len, next_len;
  logic [PW-1:0] spec, comm, base_ptr, next_ptr;
  logic start, cont, coll_early, coll_late, base_bad, room, want, refuse;
  logic frame_late, is_end, short_f, passes, keep, ovf_now;

  always_comb begin
    start      = in_valid & in_sof;
    cont       = in_valid & ~in_sof & active;
    coll_early = col_det & active & ~start & (bit_time < SLOT_P);
    coll_late  = col_det & active & ~start & (bit_time >= SLOT_P);
    base_ptr   = start ? comm : spec;
    base_bad   = ~start & bad;
    next_len   = (start ? '0 : len) + LEN_W'(1);
    room       = (base_ptr - rd_ptr) != DEPTH_P;
    want       = (start | cont) & ~coll_early & ~base_bad;
    wr_en      = want & room;
    refuse     = want & ~room;
    next_ptr   = base_ptr + {{(PW-1){1'b0}}, wr_en};
    frame_late = (~start & late) | coll_late;
    is_end     = (start | cont) & in_eof & ~coll_early;
    short_f    = next_len < MIN_P;
    passes     = is_end & ~base_bad & ~refuse & ~(short_f & ~runt_ok);
    keep       = passes & ~meta_full;
    ovf_now    = refuse | (passes & meta_full);
  end

  assign wr_ptr              = base_ptr;
  assign comm_ptr            = comm;
  assign push                = keep;
  assign push_len            = next_len;
  assign push_stat.late_coll = frame_late;
  assign push_stat.short_frm = short_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      bad       <= 1'b0;
      late      <= 1'b0;
      len       <= '0;
      spec      <= '0;
      comm      <= '0;
      ovf_event <= 1'b0;
    end else begin
      ovf_event <= ovf_now;
      if (coll_early) begin
        active <= 1'b0;
        spec   <= comm;
      end else if (start | cont) begin
        len  <= next_len;
        late <= frame_late;
        if (in_eof) begin
          active <= 1'b0;
          bad    <= 1'b0;
          if (keep) begin
            comm <= next_ptr;
            spec <= next_ptr;
          end else begin
            spec <= comm;
          end
        end else begin
          active <= 1'b1;
          bad    <= base_bad | refuse;
          spec   <= (base_bad | refuse) ? comm : next_ptr;
        end
      end else if (coll_late) begin
        late <= 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (spec - rd_ptr) <= DEPTH_P) // R8
    else $error("speculative pointer beyond queue depth");
  AST_COMMIT_AT_END: assert property (@(posedge clk) disable iff (rst) !(in_valid && in_eof) |=> $stable(comm)) // R1
    else $error("commit without end of frame");
  AST_EARLY_DROP: assert property (@(posedge clk) disable iff (rst) (col_det && active && !(in_valid && in_sof) && bit_time < SLOT_P) |=> (spec == comm)) // R2
    else $error("early collision did not retract frame");
  AST_RUNT_DROP: assert property (@(posedge clk) disable iff (rst) (in_valid && in_eof && (in_sof || active) && !runt_ok && next_len < MIN_P) |=> $stable(comm)) // R4
    else $error("runt frame committed");
endmodule

// File: rtl/rxq_rd_ctl.sv
`timescale 1ns/1ps
module rxq_rd_ctl #(
  parameter int DEPTH = 128,
  localparam int PW    = $clog2(DEPTH) + 1,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             out_ready,
  input  logic             meta_valid,
  input  logic [LEN_W-1:0] head_len,
  output logic             out_valid,
  output logic             out_last,
  output logic [PW-1:0]    rd_ptr,
  output logic             pop
);
  logic [LEN_W-1:0] cnt;
  logic [PW-1:0] rp;
  logic fire;

  assign out_valid = meta_valid;
  assign out_last  = (cnt == head_len - LEN_W'(1));
  assign fire      = out_valid & out_ready;
  assign pop       = fire & out_last;
  assign rd_ptr    = rp;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      rp  <= '0;
    end else if (fire) begin
      rp  <= rp + PW'(1);
      cnt <= out_last ? '0 : cnt + LEN_W'(1);
    end
  end
endmodule

// File: rtl/rxq_reject_fifo.sv
`timescale 1ns/1ps
module rxq_reject_fifo #(
  parameter int DEPTH      = 128,
  parameter int META_DEPTH = 8,
  parameter int MIN_LEN    = 64,
  parameter int SLOT_BITS  = 512,
  parameter int BT_W       = 12,
  localparam int PW    = $clog2(DEPTH) + 1,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             col_det,
  input  logic [BT_W-1:0]  bit_time,
  input  logic             runt_accept,
  input  logic             loop_en,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [LEN_W-1:0] out_len,
  output logic [1:0]       out_stat,
  output logic [PW-1:0]    q_level,
  output logic             q_empty,
  output logic             ovf_event
);
  localparam int MW = LEN_W + 2;

  logic wr_en, push, pop, meta_full, meta_valid;
  logic [PW-1:0] wr_ptr, comm_ptr, rd_ptr;
  logic [LEN_W-1:0] push_len;
  rxq_pkg::rxq_stat_t push_stat;
  logic [MW-1:0] head;

  assign in_ready = 1'b1;

  rxq_wr_ctl #(.DEPTH(DEPTH), .MIN_LEN(MIN_LEN), .SLOT_BITS(SLOT_BITS), .BT_W(BT_W)) u_wr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .col_det(col_det), .bit_time(bit_time), .runt_ok(runt_accept | loop_en),
    .rd_ptr(rd_ptr), .meta_full(meta_full), .wr_en(wr_en), .wr_ptr(wr_ptr),
    .comm_ptr(comm_ptr), .push(push), .push_len(push_len), .push_stat(push_stat),
    .ovf_event(ovf_event)
  );

  rxq_byte_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_ptr[PW-2:0]), .wdata(in_data),
    .raddr(rd_ptr[PW-2:0]), .rdata(out_data)
  );

  rxq_meta_fifo #(.W(MW), .DEPTH(META_DEPTH)) u_meta (
    .clk(clk), .rst(rst), .push(push), .din({push_len, push_stat}), .pop(pop),
    .dout(head), .valid(meta_valid), .full(meta_full)
  );

  rxq_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst(rst), .out_ready(out_ready), .meta_valid(meta_valid),
    .head_len(head[MW-1:2]), .out_valid(out_valid), .out_last(out_last),
    .rd_ptr(rd_ptr), .pop(pop)
  );

  assign out_len  = head[MW-1:2];
  assign out_stat = head[1:0];
  assign q_level  = comm_ptr - rd_ptr;
  assign q_empty  = (q_level == '0);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_len))) // R11
    else $error("output changed under back-pressure");
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst) q_empty |-> !out_valid) // R7
    else $error("output valid with no committed bytes");
endmodule

// File: tb/rxq_reject_fifo_tb.sv
`timescale 1ns/1ps
module rxq_reject_fifo_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_sof = 0, in_eof = 0, col_det = 0, runt_accept = 0, loop_en = 0;
  logic [7:0] in_data = '0;
  logic [11:0] bit_time = '0;
  logic in_ready, out_valid, out_ready, out_last, q_empty, ovf_event;
  logic [7:0] out_data, out_len, q_level;
  logic [1:0] out_stat;

  int checks = 0, fails = 0, ovf_cnt = 0;
  bit stall = 1'b1, done = 1'b0;
  logic [7:0] exp_d[$];
  bit exp_l[$];
  int exp_len[$];
  logic [1:0] exp_st[$];

  always #4 clk = ~clk;

  rxq_reject_fifo u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .col_det(col_det), .bit_time(bit_time),
    .runt_accept(runt_accept), .loop_en(loop_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .out_len(out_len),
    .out_stat(out_stat), .q_level(q_level), .q_empty(q_empty), .ovf_event(ovf_event)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit keeps(input int len, input bit early, input bit ra, input bit lb);
    return !early && (len >= 64 || ra || lb);
  endfunction

  // reader: stalls on request, otherwise random back-pressure
  initial begin
    out_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      out_ready = stall ? 1'b0 : ($urandom % 4 != 0);
    end
  end

  // output monitor against the expected stream (R1, R2, R3, R5)
  always @(negedge clk) begin
    if (!rst && ovf_event) ovf_cnt++;
    if (!rst && out_valid && out_ready) begin
      if (exp_d.size() == 0) begin
        chk(1'b0, "R2", "unexpected output byte", out_data, -1);
      end else begin
        chk(out_data == exp_d[0], "R1", "data", out_data, exp_d[0]);
        chk(out_last == exp_l[0], "R1", "last", out_last, exp_l[0]);
        chk(out_len == exp_len[0], "R1", "length", out_len, exp_len[0]);
        chk(out_stat == exp_st[0], "R3_R5", "status", out_stat, exp_st[0]);
        void'(exp_d.pop_front()); void'(exp_l.pop_front());
        void'(exp_len.pop_front()); void'(exp_st.pop_front());
      end
    end
  end

  task automatic send_frame(input int len, input int cidx, input int cbt, input bit ra,
                            input bit lb, input bit with_eof, input bit will_ovf, input bit gaps);
    logic [7:0] d[$];
    bit early;
    early = (cidx >= 0) && (cbt < 512);
    for (int i = 0; i < len; i++) d.push_back(8'($urandom));
    if (with_eof && !will_ovf && keeps(len, early, ra, lb))
      for (int i = 0; i < len; i++) begin
        exp_d.push_back(d[i]);
        exp_l.push_back(i == len - 1);
        exp_len.push_back(len);
        exp_st.push_back({len < 64, (cidx >= 0) && (cbt >= 512)});
      end
    runt_accept = ra;
    loop_en = lb;
    for (int i = 0; i < len; i++) begin
      if (gaps)
        while ($urandom % 5 == 0) begin
          @(posedge clk); #1;
          in_valid = 0; col_det = 0;
        end
      @(posedge clk); #1;
      in_valid = 1;
      in_sof = (i == 0);
      in_eof = with_eof && (i == len - 1);
      in_data = d[i];
      col_det = (i == cidx);
      bit_time = (i == cidx) ? 12'(cbt) : 12'(i * 8);
    end
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0; col_det = 0;
  endtask

  task automatic set_stall(input bit s);
    stall = s;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic wait_drain();
    int n = 0;
    while ((exp_d.size() != 0 || q_level != 0) && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lvl, ov0;
    logic [7:0] held;
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!out_valid && q_level == 0 && q_empty, "R12", "reset state", q_level, 0);

    // R1: plain frame, reader running
    set_stall(0);
    send_frame(70, -1, 0, 0, 0, 1, 0, 0);
    wait_drain();

    // R7: bytes of an open frame stay invisible; R1 latency
    set_stall(1);
    fork
      send_frame(80, -1, 0, 0, 0, 1, 0, 0);
      begin
        repeat (40) @(negedge clk);
        chk(!out_valid && q_level == 0 && q_empty, "R7", "open frame visible", q_level, 0);
      end
    join
    @(negedge clk);
    chk(q_level == 80 && out_valid, "R1", "level after commit", q_level, 80);

    // R11: held under back-pressure
    held = out_data;
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == held, "R11", "held byte", out_data, held);

    // R2 and R6: early collision behind a committed frame
    send_frame(90, 20, 160, 0, 0, 1, 0, 0);
    @(negedge clk);
    chk(q_level == 80, "R6", "level after early collision drop", q_level, 80);

    // R4: runt with acceptance off
    send_frame(40, -1, 0, 0, 0, 1, 0, 0);
    @(negedge clk);
    chk(q_level == 80, "R4", "level after runt drop", q_level, 80);

    // R8: overflow drops the frame, one pulse
    ov0 = ovf_cnt;
    send_frame(60, -1, 0, 1, 0, 1, 1, 0);
    @(negedge clk);
    chk(ovf_cnt == ov0 + 1, "R8", "overflow pulses", ovf_cnt - ov0, 1);
    chk(q_level == 80, "R8", "level after overflow", q_level, 80);

    // R5: loopback forces runt acceptance, then programmed acceptance
    send_frame(30, -1, 0, 0, 1, 1, 0, 0);
    @(negedge clk);
    chk(q_level == 110, "R5", "loopback runt kept", q_level, 110);
    send_frame(10, -1, 0, 1, 0, 1, 0, 0);
    @(negedge clk);
    chk(q_level == 120, "R5", "accepted runt kept", q_level, 120);
    set_stall(0);
    wait_drain();

    // R3: late collision keeps the frame with status bit 0
    send_frame(100, 70, 560, 0, 0, 1, 0, 0);
    wait_drain();

    // R9: open frame abandoned by a new start
    set_stall(1);
    send_frame(15, -1, 0, 0, 0, 0, 0, 0);
    send_frame(65, -1, 0, 0, 0, 1, 0, 0);
    @(negedge clk);
    chk(q_level == 65, "R9", "level after restart", q_level, 65);
    set_stall(0);
    wait_drain();

    // R10: beats and collisions outside a frame
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_data = 8'(i); in_eof = (i == 4); col_det = (i == 2); bit_time = 12'd8;
    end
    @(posedge clk); #1;
    in_valid = 0; in_eof = 0; col_det = 0;
    repeat (2) @(negedge clk);
    chk(q_level == 0 && !out_valid, "R10", "stray beats stored", q_level, 0);

    // random mix of lengths, collisions and acceptance modes
    for (int n = 0; n < 120; n++) begin
      int len, cidx;
      len = 1 + $urandom % 120;
      cidx = ($urandom % 4 == 0 && len > 1) ? 1 + $urandom % (len - 1) : -1;
      send_frame(len, cidx, $urandom % 1024, $urandom % 4 == 0, $urandom % 4 == 0, 1, 0, 1);
      wait_drain();
    end

    chk(exp_d.size() == 0, "R1", "bytes never delivered", exp_d.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule